// File: doc/BRIEF.md
# Three-Wire Serial Register Bank Slave

This block is the peripheral end of a three-wire control link made of a serial clock, a bidirectional data line and a latch-enable strobe. It runs on its own system clock, synchronises the three link inputs and detects rising edges of the serial clock itself. Serial bits are taken in most-significant first. A standard frame starts with the 3-bit pattern 101b, then carries a direction bit, a 5-bit register address and a 16-bit data word. It reads or writes one of 32 registers of 16 bits each. The data line is split into an input, an output and an output enable so that a pad or the enclosing logic can form the bidirectional line.

Bit 0 of register 0 turns on a shortened write mode. In this mode any leading 3-bit field other than 101b selects one of the eight write-only registers at addresses 24 to 31. The frame is either 16 bits long, carrying 13 data bits, or 8 bits long, carrying 5 data bits. Address 17 holds a 32-bit register that is filled by two successive writes. Reading address 17 returns how far that filling has progressed, not the value held. The contents of the write-only registers and of the 32-bit register are brought out as ports for the logic they control.

Top module: `sreg_slave`

## Requirements
- R1: After reset, the data output enable is low, every register and the 32-bit register read as zero, and the write-only register port is zero.
- R2: A 25-bit frame with leading field 101b and a direction bit of 0 writes the 16-bit data to the addressed register. The write is committed at the first serial-clock rising edge that sees the latch strobe high.
- R3: When the direction bit is 1, the output enable stays low until the 9th rising edge and rises at that edge. The addressed data is then shifted out MSB first, one new bit per rising edge from the 9th onward. The line is released at the rising edge that sees the strobe high.
- R4: With bit 0 of register 0 clear, a frame whose leading field is not 101b changes no register.
- R5: Bit 0 of register 0 enables shortened writes. Clearing it disables them again.
- R6: With shortened writes enabled, a 16-bit frame with leading field h (h not 101b) writes its 13 data bits into bits 12:0 of register 24+h. Bits 15:13 of that register keep their value.
- R7: With shortened writes enabled, an 8-bit frame with leading field h writes its 5 data bits into bits 4:0 of register 24+h. Bits 15:5 keep their value.
- R8: A shortened frame whose length at the strobe is neither 8 nor 16 bits is discarded.
- R9: Registers 24 to 31 can also be written by standard frames, and both kinds of write update the same storage. Standard reads of these addresses return zero. Standard reads and writes keep working while shortened writes are enabled.
- R10: The first write to address 17 loads bits 31:16 of the 32-bit register and the second write loads bits 15:0. A write after both halves are loaded starts again at the high half.
- R11: A read of address 17 returns 0000h before both halves have been loaded, whether nothing or only the high half has been written. It returns 0001h once both halves are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master |
| sdat_i | input | 1 | Serial data from the master |
| sle_i | input | 1 | Latch strobe that ends a frame |
| sdat_o | output | 1 | Serial read data |
| sdat_oe_o | output | 1 | Enable for driving sdat_o onto the line |
| wo_regs_o | output | 128 | Write-only registers 24..31, register 24 in bits 15:0 |
| wide_o | output | 32 | Contents of the 32-bit register |

## Verification
The assertions assume that the master holds the data and strobe inputs steady around each serial-clock rising edge. They also assume that each serial-clock level lasts several system clocks, so that every edge is seen exactly once after synchronisation. The bench keeps each serial-clock phase four system clocks long and changes data and strobe only while the serial clock is low. Frames are never overlapped, so successive writes to address 17 always lie many serial clocks apart.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam logic [2:0] NORMAL_HDR = 3'b101;

    typedef enum logic [1:0] {
        WIDE_EMPTY = 2'd0,
        WIDE_HIGH  = 2'd1,
        WIDE_BOTH  = 2'd2
    } wide_prog_e;

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.pipe[STAGES-1];
endmodule

// File: rtl/sreg_frame_rx.sv
module sreg_frame_rx
    import sreg_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int HDR_W     = 3,
    parameter int LONG_LEN  = 16,
    parameter int SHORT_LEN = 8,
    parameter int FAST_BASE = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s_i,
    input  logic              sdat_s_i,
    input  logic              sle_s_i,
    input  logic              fast_en_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [DATA_W-1:0] wr_mask_o,
    output logic              sdat_o,
    output logic              sdat_oe_o
);
    localparam int CMD_LEN  = HDR_W + 1 + ADDR_W;
    localparam int NORM_LEN = CMD_LEN + DATA_W;
    localparam int CNT_W    = $clog2(NORM_LEN + 2);
    localparam int LONG_DW  = LONG_LEN - HDR_W;
    localparam int SHORT_DW = SHORT_LEN - HDR_W;
    localparam logic [DATA_W-1:0] FULL_MASK  = '1;
    localparam logic [DATA_W-1:0] LONG_MASK  = DATA_W'((1 << LONG_DW) - 1);
    localparam logic [DATA_W-1:0] SHORT_MASK = DATA_W'((1 << SHORT_DW) - 1);

    typedef struct packed {
        logic                sclk_prev;
        logic [CNT_W-1:0]    cnt;
        logic [NORM_LEN-1:0] sh;
        logic [DATA_W-1:0]   out;
        logic                oe;
        logic                wr;
        logic [ADDR_W-1:0]   wa;
        logic [DATA_W-1:0]   wd;
        logic [DATA_W-1:0]   wm;
    } st_t;

    st_t st_d, st_q;
    logic                rise;
    logic [NORM_LEN-1:0] sh_in;
    logic [HDR_W-1:0]    hdr_long, hdr_short;

    assign rise      = sclk_s_i & ~st_q.sclk_prev;
    assign sh_in     = {st_q.sh[NORM_LEN-2:0], sdat_s_i};
    assign rd_addr_o = sh_in[ADDR_W-1:0];
    assign hdr_long  = st_q.sh[LONG_LEN-1 -: HDR_W];
    assign hdr_short = st_q.sh[SHORT_LEN-1 -: HDR_W];

    always_comb begin
        st_d = st_q;
        st_d.sclk_prev = sclk_s_i;
        st_d.wr = 1'b0;
        if (rise && !sle_s_i) begin
            st_d.sh = sh_in;
            if (st_q.cnt != '1) st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.oe) st_d.out = {st_q.out[DATA_W-2:0], 1'b0};
            if (st_q.cnt == CNT_W'(CMD_LEN - 1)
                && sh_in[CMD_LEN-1 -: HDR_W] == NORMAL_HDR
                && sh_in[ADDR_W]) begin
                st_d.oe  = 1'b1;
                st_d.out = rd_data_i;
            end
        end else if (rise && sle_s_i) begin
            st_d.cnt = '0;
            st_d.oe  = 1'b0;
            if (st_q.cnt == CNT_W'(NORM_LEN)
                && st_q.sh[NORM_LEN-1 -: HDR_W] == NORMAL_HDR
                && !st_q.sh[DATA_W + ADDR_W]) begin
                st_d.wr = 1'b1;
                st_d.wa = st_q.sh[DATA_W +: ADDR_W];
                st_d.wd = st_q.sh[DATA_W-1:0];
                st_d.wm = FULL_MASK;
            end else if (fast_en_i && st_q.cnt == CNT_W'(LONG_LEN)
                         && hdr_long != NORMAL_HDR) begin
                st_d.wr = 1'b1;
                st_d.wa = ADDR_W'(FAST_BASE) + ADDR_W'(hdr_long);
                st_d.wd = DATA_W'(st_q.sh[LONG_DW-1:0]);
                st_d.wm = LONG_MASK;
            end else if (fast_en_i && st_q.cnt == CNT_W'(SHORT_LEN)
                         && hdr_short != NORMAL_HDR) begin
                st_d.wr = 1'b1;
                st_d.wa = ADDR_W'(FAST_BASE) + ADDR_W'(hdr_short);
                st_d.wd = DATA_W'(st_q.sh[SHORT_DW-1:0]);
                st_d.wm = SHORT_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en_o   = st_q.wr;
    assign wr_addr_o = st_q.wa;
    assign wr_data_o = st_q.wd;
    assign wr_mask_o = st_q.wm;
    assign sdat_oe_o = st_q.oe;
    assign sdat_o    = st_q.oe & st_q.out[DATA_W-1];

    // R3
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.oe) |-> $past(rise && sle_s_i));

    // R3
    oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.oe) |-> st_q.cnt == CNT_W'(CMD_LEN));

    // R2
    commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(rise && sle_s_i));

    // R4
    short_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_mask_o != FULL_MASK) |-> $past(fast_en_i));
endmodule

// File: rtl/sreg_store.sv
module sreg_store
    import sreg_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int HDR_W     = 3,
    parameter int FAST_BASE = 24,
    parameter int WIDE_ADDR = 17,
    parameter int CTRL_ADDR = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en_i,
    input  logic [ADDR_W-1:0]             wr_addr_i,
    input  logic [DATA_W-1:0]             wr_data_i,
    input  logic [DATA_W-1:0]             wr_mask_i,
    input  logic [ADDR_W-1:0]             rd_addr_i,
    output logic [DATA_W-1:0]             rd_data_o,
    output logic                          fast_en_o,
    output logic [(1<<HDR_W)*DATA_W-1:0]  wo_regs_o,
    output logic [2*DATA_W-1:0]           wide_o
);
    localparam int NREG  = 1 << ADDR_W;
    localparam int NFAST = 1 << HDR_W;

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
        logic [2*DATA_W-1:0]         wide;
        wide_prog_e                  prog;
    } st_t;

    st_t st_d, st_q;
    logic wide_hit;

    assign wide_hit = (wr_addr_i == ADDR_W'(WIDE_ADDR));

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            if (wide_hit) begin
                if (st_q.prog == WIDE_HIGH) begin
                    st_d.wide[DATA_W-1:0] = wr_data_i;
                    st_d.prog = WIDE_BOTH;
                end else begin
                    st_d.wide[2*DATA_W-1:DATA_W] = wr_data_i;
                    st_d.prog = WIDE_HIGH;
                end
            end else begin
                st_d.regs[wr_addr_i] = (st_q.regs[wr_addr_i] & ~wr_mask_i)
                                     | (wr_data_i & wr_mask_i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (rd_addr_i == ADDR_W'(WIDE_ADDR))
            rd_data_o = DATA_W'(st_q.prog == WIDE_BOTH);
        else if (int'(rd_addr_i) >= FAST_BASE && int'(rd_addr_i) < FAST_BASE + NFAST)
            rd_data_o = '0;
        else
            rd_data_o = st_q.regs[rd_addr_i];
    end

    assign fast_en_o = st_q.regs[CTRL_ADDR][0];
    assign wide_o    = st_q.wide;

    for (genvar i = 0; i < NFAST; i++) begin : g_wo
        assign wo_regs_o[i*DATA_W +: DATA_W] = st_q.regs[FAST_BASE + i];
    end

    // R10
    wide_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wide_hit && st_q.prog != WIDE_HIGH)
        |=> (st_q.prog == WIDE_HIGH && st_q.wide[2*DATA_W-1:DATA_W] == $past(wr_data_i)));

    // R11
    wide_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wide_hit && st_q.prog == WIDE_HIGH)
        |=> (st_q.prog == WIDE_BOTH && st_q.wide[DATA_W-1:0] == $past(wr_data_i)));
endmodule

// File: rtl/sreg_slave.sv
module sreg_slave #(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int HDR_W     = 3,
    parameter int LONG_LEN  = 16,
    parameter int SHORT_LEN = 8,
    parameter int FAST_BASE = 24,
    parameter int WIDE_ADDR = 17,
    parameter int CTRL_ADDR = 0,
    parameter int SYNC_STG  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sclk_i,
    input  logic                          sdat_i,
    input  logic                          sle_i,
    output logic                          sdat_o,
    output logic                          sdat_oe_o,
    output logic [(1<<HDR_W)*DATA_W-1:0]  wo_regs_o,
    output logic [2*DATA_W-1:0]           wide_o
);
    logic [2:0]        sync_v;
    logic              fast_en;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data, wr_mask;

    sreg_sync #(.W(3), .STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sle_i, sdat_i, sclk_i}),
        .sync_o  (sync_v)
    );

    sreg_frame_rx #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HDR_W(HDR_W),
        .LONG_LEN(LONG_LEN), .SHORT_LEN(SHORT_LEN), .FAST_BASE(FAST_BASE)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s_i  (sync_v[0]),
        .sdat_s_i  (sync_v[1]),
        .sle_s_i   (sync_v[2]),
        .fast_en_i (fast_en),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .wr_mask_o (wr_mask),
        .sdat_o    (sdat_o),
        .sdat_oe_o (sdat_oe_o)
    );

    sreg_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HDR_W(HDR_W),
        .FAST_BASE(FAST_BASE), .WIDE_ADDR(WIDE_ADDR), .CTRL_ADDR(CTRL_ADDR)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .wr_mask_i (wr_mask),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .fast_en_o (fast_en),
        .wo_regs_o (wo_regs_o),
        .wide_o    (wide_o)
    );
endmodule

// File: tb/sreg_slave_tb.sv
module sreg_slave_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
    logic sdat_o, sdat_oe;
    logic [127:0] wo_regs;
    logic [31:0]  wide;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] mregs [32];
    int          mprog = 0;
    logic [31:0] mwide = '0;

    always #2 clk = ~clk;

    sreg_slave dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdat_i(sdat), .sle_i(sle),
        .sdat_o(sdat_o), .sdat_oe_o(sdat_oe), .wo_regs_o(wo_regs), .wide_o(wide)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b);
        sdat = b;
        half();
        sclk = 1'b1;
        half();
        sclk = 1'b0;
    endtask

    task automatic end_frame();
        sle = 1'b1;
        half();
        sclk = 1'b1;
        half();
        sclk = 1'b0;
        sle = 1'b0;
        half();
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) clock_bit(v[i]);
        end_frame();
    endtask

    function automatic bit fast_on();
        return mregs[0][0];
    endfunction

    task automatic model_write(input int a, input logic [15:0] d, input logic [15:0] m);
        if (a == 17) begin
            if (mprog == 1) begin mwide[15:0] = d; mprog = 2; end
            else begin mwide[31:16] = d; mprog = 1; end
        end else begin
            mregs[a] = (mregs[a] & ~m) | (d & m);
        end
    endtask

    function automatic logic [15:0] exp_read(input int a);
        if (a == 17) return (mprog == 2) ? 16'h0001 : 16'h0000;
        if (a >= 24) return 16'h0000;
        return mregs[a];
    endfunction

    task automatic do_write(input int a, input logic [15:0] d);
        send({7'b0, 3'b101, 1'b0, 5'(a), d}, 25);
        model_write(a, d, 16'hffff);
    endtask

    task automatic fast16(input logic [2:0] h, input logic [12:0] d);
        send({16'b0, h, d}, 16);
        if (fast_on() && h != 3'b101) model_write(24 + int'(h), {3'b0, d}, 16'h1fff);
    endtask

    task automatic fast8(input logic [2:0] h, input logic [4:0] d);
        send({24'b0, h, d}, 8);
        if (fast_on() && h != 3'b101) model_write(24 + int'(h), {11'b0, d}, 16'h001f);
    endtask

    task automatic do_read(input int a, input string req);
        logic [8:0]  cmd;
        logic [15:0] got;
        int oe_low;
        cmd = {3'b101, 1'b1, 5'(a)};
        oe_low = 0;
        got = '0;
        for (int i = 8; i >= 0; i--) begin
            sdat = cmd[i];
            half();
            if (i == 0) chk({req, " R3 oe low before 9th edge"}, {31'b0, sdat_oe}, 32'd0);
            sclk = 1'b1;
            half();
            sclk = 1'b0;
        end
        for (int k = 15; k >= 0; k--) begin
            sdat = 1'b0;
            half();
            got[k] = sdat_o;
            if (!sdat_oe) oe_low++;
            sclk = 1'b1;
            half();
            sclk = 1'b0;
        end
        chk({req, " R3 oe held during data"}, oe_low, 0);
        chk(req, {16'b0, got}, {16'b0, exp_read(a)});
        end_frame();
        chk({req, " R3 line released"}, {31'b0, sdat_oe}, 32'd0);
    endtask

    task automatic check_wo(input string req);
        logic [127:0] e;
        for (int i = 0; i < 8; i++) e[i*16 +: 16] = mregs[24 + i];
        checks++;
        if (wo_regs !== e) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, wo_regs, e);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1234_5678);
        for (int i = 0; i < 32; i++) mregs[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 oe", {31'b0, sdat_oe}, 0);
        chk("R1 wide", wide, 0);
        check_wo("R1 wo regs");
        do_read(3, "R1 read reg3");
        do_read(17, "R1 R11 read wide empty");

        // R2 standard write and read back
        do_write(5, 16'hA5C3);
        do_read(5, "R2 reg5");
        do_write(12, 16'h8001);
        do_read(12, "R2 reg12 msb/lsb");

        // R4 bad header discarded with shortened writes off
        send({7'b0, 3'b011, 1'b0, 5'd6, 16'hFFFF}, 25);
        do_read(6, "R4 reg6 untouched");
        fast16(3'd2, 13'h1555);
        check_wo("R4 short frame ignored while disabled");

        // R9 standard access to write-only registers
        do_write(26, 16'hBEEF);
        do_read(26, "R9 write-only reads zero");
        check_wo("R9 standard write reaches wo reg");
        do_write(27, 16'hFFFF);
        do_write(31, 16'hFFFF);

        // R10 / R11 32-bit register
        do_write(17, 16'h1234);
        chk("R10 high half", wide, 32'h1234_0000);
        do_read(17, "R11 high only reads 0");
        do_write(17, 16'h5678);
        chk("R10 low half", wide, 32'h1234_5678);
        do_read(17, "R11 both reads 1");
        do_write(17, 16'h9ABC);
        chk("R10 restart high", wide, 32'h9ABC_5678);
        do_read(17, "R11 restart reads 0");

        // R5 enable shortened writes
        do_write(0, 16'h0001);
        do_read(0, "R5 ctrl readback");
        // R6 16-bit shortened frame keeps bits 15:13
        fast16(3'd3, 13'h0ABC);
        check_wo("R6 long short-frame to reg27");
        // R7 8-bit shortened frame keeps bits 15:5
        fast8(3'd7, 5'h0A);
        check_wo("R7 8-bit frame to reg31");
        chk("R7 reg31 value", {16'b0, wo_regs[127:112]}, 32'h0000_FFEA);
        // R8 wrong length discarded
        send({20'b0, 3'd4, 9'h1FF}, 12);
        check_wo("R8 12-bit frame discarded");
        // R9 standard ops still valid while enabled
        do_write(9, 16'h0F0F);
        do_read(9, "R9 reg9 with fast on");
        // R5 disable again
        do_write(0, 16'h0000);
        fast8(3'd0, 5'h1F);
        check_wo("R5 disabled again");

        // random mix
        for (int n = 0; n < 60; n++) begin
            int op;
            int a;
            logic [2:0] h;
            op = int'($urandom_range(0, 4));
            a  = int'($urandom_range(0, 31));
            h  = 3'($urandom_range(0, 7));
            if (h == 3'b101) h = 3'b110;
            case (op)
                0: do_write(a, 16'($urandom));
                1: do_read(a, "R2 R9 random read");
                2: begin fast16(h, 13'($urandom)); check_wo("R6 random"); end
                3: begin fast8(h, 5'($urandom)); check_wo("R7 random"); end
                default: do_write(0, {15'($urandom), 1'($urandom)});
            endcase
        end
        do_read(17, "R11 final wide progress");
        chk("R10 final wide", wide, mwide);
        check_wo("R6 final wo regs");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule